// File: doc/BRIEF.md
# Histogram Bin Increment Sequencer

This block runs the update of one bin in a pulse-height histogram. While armed, it waits for a convert strobe that can arrive at any time relative to the system clock. It then gives an external sampled-value source two clock pulses and takes the sample as the bin address. It reads that bin's count from a dual-port memory, latches the count plus one, writes the result back and signals completion. The front end uses the completion signal to discharge its hold stage before the next event.

The block holds two cooperating state machines. The first is a capture flag, which records a synchronised strobe edge seen while the block is armed. The second is the main sequencer on the system clock, which runs a fixed read, increment and write timeline. An end-of-run input from the preset counter returns both machines to the initial state at any point. An asynchronous clear does the same and also drops every output. An enable input moves the sequencer from the initial state to the armed state.

Top module: `hist_rmw_seq`

## Requirements
- R1: While `clear` is high, and until a later clock edge finds `enable` high, all outputs are 0. This includes `armed` and `overflow`.
- R2: In the initial state, a clock edge with `enable` high makes `armed` 1 after that edge. `armed` is 1 only while the sequencer is idle and ready for an event.
- R3: A rising edge on `conv_strobe` passes through a two-flop synchroniser and starts exactly one update cycle if it arrives while the block is armed. Edges that arrive while a cycle runs, or while the block is in the initial state, cause no conversion pulse and no write.
- R4: Each cycle gives exactly two `conv_clk` pulses. Each pulse is high for one cycle, and the two rising edges are two cycles apart. `sample` is taken as the bin address at the edge that ends the second pulse.
- R5: `mem_oe` is high for exactly two consecutive cycles, starting the cycle after the second `conv_clk` pulse. The count plus one is latched at the edge that ends the second of these cycles.
- R6: `mem_we` is high for exactly one cycle, four cycles after `mem_oe` rises. During that cycle `mem_wdata` equals the previous bin content plus one, and `mem_addr` holds the sampled bin.
- R7: `conv_done` is high for exactly three cycles, starting the cycle after `mem_we`. On the next cycle `armed` is 1 again.
- R8: The count wraps from all ones to 0. A bin that held all ones sets `overflow`, which stays 1 until `clear`.
- R9: `abort` high at a clock edge returns both machines to the initial state at that edge. The interrupted cycle then produces no write, no further pulse and no completion.
- R10: The address width `AW` (up to 10 bits) and the count width `DW` are parameters. Every bin in the range 0 to 2^AW-1 can be addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear | input | 1 | Asynchronous clear, active high |
| enable | input | 1 | Accumulation enable from the preset counter |
| abort | input | 1 | End of run; forces the initial state |
| conv_strobe | input | 1 | Asynchronous convert strobe |
| sample | input | AW | Sampled value from the converter |
| conv_clk | output | 1 | Clock pulses to the converter |
| conv_done | output | 1 | Conversion complete, three cycles |
| mem_addr | output | AW | Bin address to the memory |
| mem_rdata | input | DW | Count read from the memory |
| mem_wdata | output | DW | Incremented count to the memory |
| mem_oe | output | 1 | Memory output enable |
| mem_we | output | 1 | Memory write strobe |
| armed | output | 1 | Idle and ready for a strobe |
| overflow | output | 1 | Sticky count wrap flag |

## Verification
The bench builds the block with AW=4 and DW=4, which gives 16 bins of 4-bit counts. With that configuration the bench visits every bin in one sweep, and 16 events on a single bin are enough to reach the wrap and the sticky overflow flag. The same small configuration keeps each event short, so the bench can also measure every pulse width and spacing, and test strobes in the initial state, strobes during a running cycle, an abort in the middle of a read, and an asynchronous clear.

// File: rtl/hist_rmw_seq.sv
module hist_rmw_seq #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          enable,
  input  logic          abort,
  input  logic          conv_strobe,
  input  logic [AW-1:0] sample,
  output logic          conv_clk,
  output logic          conv_done,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_oe,
  output logic          mem_we,
  output logic          armed,
  output logic          overflow
);
  typedef enum logic [3:0] {
    S_INIT, S_ARMED, S_CK1, S_CKLO, S_CK2, S_RD, S_LAT,
    S_HOLD, S_DRV, S_WR, S_DN1, S_DN2, S_DN3
  } st_t;

  st_t st, nx;
  logic [2:0] sync;
  logic grab;
  logic [DW-1:0] sum;
  logic [AW-1:0] bin;

  wire strobe_edge = sync[1] & ~sync[2];

  always_ff @(posedge clk or posedge clear)
    if (clear) sync <= '0;
    else       sync <= {sync[1:0], conv_strobe};

  always_ff @(posedge clk or posedge clear)
    if (clear)                     grab <= 1'b0;
    else if (abort || st == S_CK1) grab <= 1'b0;
    else if (st == S_ARMED && strobe_edge) grab <= 1'b1;

  always_comb begin
    nx = st;
    case (st)
      S_INIT:  if (enable) nx = S_ARMED;
      S_ARMED: if (grab)   nx = S_CK1;
      S_CK1:   nx = S_CKLO;
      S_CKLO:  nx = S_CK2;
      S_CK2:   nx = S_RD;
      S_RD:    nx = S_LAT;
      S_LAT:   nx = S_HOLD;
      S_HOLD:  nx = S_DRV;
      S_DRV:   nx = S_WR;
      S_WR:    nx = S_DN1;
      S_DN1:   nx = S_DN2;
      S_DN2:   nx = S_DN3;
      S_DN3:   nx = S_ARMED;
      default: nx = S_INIT;
    endcase
    if (abort) nx = S_INIT;
  end

  always_ff @(posedge clk or posedge clear)
    if (clear) st <= S_INIT;
    else       st <= nx;

  always_ff @(posedge clk or posedge clear)
    if (clear) begin
      bin      <= '0;
      sum      <= '0;
      overflow <= 1'b0;
    end else begin
      if (st == S_CK2) bin <= sample;
      if (st == S_LAT && !abort) begin
        sum <= mem_rdata + 1'b1;
        if (&mem_rdata) overflow <= 1'b1;
      end
    end

  assign conv_clk  = (st == S_CK1) || (st == S_CK2);
  assign mem_oe    = (st == S_RD)  || (st == S_LAT);
  assign mem_we    = (st == S_WR);
  assign conv_done = (st == S_DN1) || (st == S_DN2) || (st == S_DN3);
  assign armed     = (st == S_ARMED);
  assign mem_addr  = bin;
  assign mem_wdata = sum;
endmodule

module hist_rmw_seq_chk (
  input logic clk,
  input logic clear,
  input logic abort,
  input logic conv_clk,
  input logic conv_done,
  input logic mem_oe,
  input logic mem_we,
  input logic armed,
  input logic overflow
);
  // R6
  we_single_chk: assert property (@(posedge clk) disable iff (clear)
    mem_we |=> !mem_we);
  // R6
  we_after_oe_chk: assert property (@(posedge clk) disable iff (clear)
    $rose(mem_we) |-> ($past(mem_oe, 3) && !$past(mem_oe, 2) && !$past(mem_oe, 1)));
  // R7
  done_follows_write_chk: assert property (@(posedge clk) disable iff (clear)
    mem_we |=> conv_done);
  // R4
  clk_no_oe_chk: assert property (@(posedge clk) disable iff (clear)
    !(conv_clk && (mem_oe || mem_we || conv_done)));
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (clear)
    abort |=> (!conv_clk && !mem_oe && !mem_we && !conv_done && !armed));
  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (clear)
    overflow |=> overflow);
  // R2
  armed_idle_chk: assert property (@(posedge clk) disable iff (clear)
    armed |-> (!conv_clk && !mem_oe && !mem_we && !conv_done));
endmodule

bind hist_rmw_seq hist_rmw_seq_chk u_chk (
  .clk(clk), .clear(clear), .abort(abort), .conv_clk(conv_clk),
  .conv_done(conv_done), .mem_oe(mem_oe), .mem_we(mem_we),
  .armed(armed), .overflow(overflow)
);

// File: tb/hist_rmw_seq_test.sv
module hist_rmw_seq_test;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic clear = 1'b1, enable = 1'b0, abort = 1'b0, conv_strobe = 1'b0;
  logic [AW-1:0] sample = '0;
  logic conv_clk, conv_done, mem_oe, mem_we, armed, overflow;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic [DW-1:0] mem [NB];
  int exp_cnt [NB];
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  hist_rmw_seq #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .clear(clear), .enable(enable), .abort(abort),
    .conv_strobe(conv_strobe), .sample(sample), .conv_clk(conv_clk),
    .conv_done(conv_done), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_oe(mem_oe), .mem_we(mem_we),
    .armed(armed), .overflow(overflow)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int cyc = 0, nclk = 0, noe = 0, nwe = 0, ndone = 0;
  int t_clk1 = 0, t_clk2 = 0, t_oe = 0, t_we = 0, t_done = 0;
  logic pclk = 0, poe = 0, pdone = 0;
  always @(negedge clk) begin
    cyc++;
    if (conv_clk && !pclk) begin
      nclk++;
      if (nclk == 1) t_clk1 = cyc; else t_clk2 = cyc;
    end
    if (mem_oe) begin noe++; if (!poe) t_oe = cyc; end
    if (mem_we) begin nwe++; t_we = cyc; end
    if (conv_done) begin ndone++; if (!pdone) t_done = cyc; end
    pclk = conv_clk; poe = mem_oe; pdone = conv_done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic zero_mon();
    @(posedge clk);
    nclk = 0; noe = 0; nwe = 0; ndone = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_strobe();
    @(negedge clk) conv_strobe = 1'b1;
    wait_n(2);
    conv_strobe = 1'b0;
  endtask

  task automatic one_event(input int b, input bit full);
    zero_mon();
    sample = AW'(b);
    pulse_strobe();
    wait_n(30);
    exp_cnt[b] = (exp_cnt[b] + 1) % (1 << DW);
    chk(int'(mem[b]) == exp_cnt[b], "R6 bin content", int'(mem[b]), exp_cnt[b]);
    if (full) begin
      chk(nclk == 2, "R4 conv_clk pulses", nclk, 2);
      chk(t_clk2 == t_clk1 + 2, "R4 pulse spacing", t_clk2 - t_clk1, 2);
      chk(noe == 2 && t_oe == t_clk2 + 1, "R5 oe window", noe, 2);
      chk(nwe == 1 && t_we == t_oe + 4, "R6 we timing", t_we - t_oe, 4);
      chk(ndone == 3 && t_done == t_we + 1, "R7 done width", ndone, 3);
      chk(armed == 1'b1, "R7 rearmed", armed, 1);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mem[i] = '0; exp_cnt[i] = 0; end
    wait_n(3);
    // R1 reset state
    chk({conv_clk, conv_done, mem_oe, mem_we, armed, overflow} == 6'b0, "R1 outputs in clear",
        int'({conv_clk, conv_done, mem_oe, mem_we, armed, overflow}), 0);
    clear = 1'b0;
    wait_n(2);
    chk(armed == 1'b0, "R1 stays initial without enable", armed, 0);
    // R3 strobe in initial state ignored
    zero_mon();
    pulse_strobe();
    wait_n(25);
    chk(nclk == 0 && nwe == 0, "R3 strobe while not armed", nclk + nwe, 0);
    // R2 arming
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
    chk(armed == 1'b1, "R2 armed after enable edge", armed, 1);
    wait_n(25);
    chk(nclk == 0, "R3 early strobe not kept", nclk, 0);
    // R10 sweep every bin
    for (int b = 0; b < NB; b++) one_event(b, b < 3 || b == NB - 1);
    for (int b = 0; b < NB; b++) one_event(b, 1'b0);
    // R3 second strobe during busy
    zero_mon();
    sample = AW'(5);
    pulse_strobe();
    wait_n(6);
    pulse_strobe();
    wait_n(40);
    exp_cnt[5] = exp_cnt[5] + 1;
    chk(nclk == 2 && nwe == 1, "R3 busy strobe ignored", nwe, 1);
    chk(int'(mem[5]) == exp_cnt[5], "R3 single increment", int'(mem[5]), exp_cnt[5]);
    // R9 abort during read
    zero_mon();
    sample = AW'(7);
    pulse_strobe();
    for (int i = 0; i < 20 && !mem_oe; i++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk({conv_clk, mem_oe, mem_we, conv_done, armed} == 5'b0, "R9 abort quiets outputs",
        int'({conv_clk, mem_oe, mem_we, conv_done, armed}), 0);
    wait_n(30);
    chk(nwe == 0 && ndone == 0, "R9 no write after abort", nwe + ndone, 0);
    chk(int'(mem[7]) == exp_cnt[7], "R9 bin untouched", int'(mem[7]), exp_cnt[7]);
    chk(armed == 1'b1, "R2 rearmed after abort", armed, 1);
    // R8 wrap on bin 0
    chk(overflow == 1'b0, "R8 no overflow yet", overflow, 0);
    while (exp_cnt[0] != NB - 1) one_event(0, 1'b0);
    chk(overflow == 1'b0, "R8 at all ones", overflow, 0);
    one_event(0, 1'b1);
    chk(int'(mem[0]) == 0, "R8 wrap to zero", int'(mem[0]), 0);
    chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
    one_event(1, 1'b0);
    chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    // R1 asynchronous clear mid cycle
    zero_mon();
    sample = AW'(3);
    pulse_strobe();
    for (int i = 0; i < 20 && !mem_oe; i++) @(negedge clk);
    #1 clear = 1'b1;
    #1;
    chk({conv_clk, conv_done, mem_oe, mem_we, armed, overflow} == 6'b0, "R1 async clear",
        int'({conv_clk, conv_done, mem_oe, mem_we, armed, overflow}), 0);
    wait_n(2);
    clear = 1'b0;
    wait_n(30);
    chk(int'(mem[3]) == exp_cnt[3], "R1 clear stops write", int'(mem[3]), exp_cnt[3]);
    one_event(3, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule